// File: doc/BRIEF.md
# Cascadable Dual Countdown Timer

Two 8-bit down-counters share a 16-bit free-running prescaler and a single system clock. Each counter reloads from its own divisor, counts down to 1, and then raises an underflow. The underflow reloads the divisor and sets a pending interrupt that stays set until software acknowledges it. A counter can take its ticks from one of four places: every system clock cycle, an external low-rate tick pulse, the prescaler's mid-period pulse, or, for the second counter only, the underflow of the first counter. That last choice chains the two counters into a 16-bit period.

Software reaches the block through two write strobes. One writes the control word, which holds the divisor, mode, tick source, interrupt-clear command and interrupt mask for both timers. The other writes the prescaler divide value. The live counts and the live prescaler count are always visible on read ports. Both counters can be loaded and held while they are stopped, so a period can be set up before the counter starts.

Top module: `dual_tick_timer`

## Requirements
- R1: While reset is asserted and right after it, both counts read 0, the prescaler count reads 2, and the interrupt outputs read 0.
- R2: The prescaler count falls by one each cycle. In a cycle where it reads 1 it reloads the stored divide value. A write on `psc_we` stores the value and loads it into the count at the same edge. A written value below 2 is taken as 2.
- R3: The prescaler tick is a one-cycle pulse in each cycle where the prescaler count equals the divide value shifted right by one. A counter on source code 2 steps only on that pulse.
- R4: Control word layout, with DW = divisor width (8): divisor of timer 0 in bits [DW-1:0], divisor of timer 1 in bits [2DW-1:DW], run bits at 2DW and 2DW+1, source fields at [2DW+3:2DW+2] and [2DW+5:2DW+4], clear bits at 2DW+6 and 2DW+7, mask bits at 2DW+8 and 2DW+9. The fields of a write already govern the counter update at the edge that takes the write. With its run bit 0, a counter holds its divisor value.
- R5: With the run bit at 1, a counter steps once per tick. On a tick at count 1 it reloads the divisor and produces an underflow. On any other tick it decrements.
- R6: Source codes: 0 ticks every cycle, 1 ticks on `slow_tick`, 2 ticks on the prescaler pulse. Code 3 chains to timer 0's underflow for timer 1 and gives no ticks for timer 0.
- R7: A running timer 1 on source 3 steps at the same edge where timer 0 underflows.
- R8: An underflow sets that timer's pending flag at the edge it occurs. The flag stays set until a control write with that timer's clear bit at 1. If an underflow and a clear fall on the same edge, the flag stays set.
- R9: A control write with a clear bit at 0 leaves that timer's pending flag unchanged.
- R10: Each interrupt output equals the pending flag ANDed with the stored mask bit. The mask takes effect from the edge after the write.
- R11: A divisor of 0 acts as 256. The count shows 0 and wraps to 255 on its first tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 26 | Control word (layout in R4) |
| psc_we | input | 1 | Prescaler divide write strobe |
| psc_wdata | input | 16 | Prescaler divide value |
| slow_tick | input | 1 | External low-rate tick, one cycle per pulse |
| cnt0 | output | 8 | Live count of timer 0 |
| cnt1 | output | 8 | Live count of timer 1 |
| psc_cnt | output | 16 | Live prescaler count |
| irq | output | 2 | Masked interrupt per timer |

## Verification
The assertions assume that `slow_tick` and the write strobes are synchronous to `clk` and last one cycle each. They also assume that a written divisor is meant to take effect at the same edge as the write. The prescaler assertions hold only when no prescaler write occurs in the sampled cycle, so they are guarded on `psc_we`. The stimulus drives every input on the falling edge and issues each write for exactly one cycle. It issues clear commands on consecutive cycles so that some of them coincide with underflows. It mixes all four source codes, including the chained source on timer 0, where no ticks are expected.

// File: rtl/dtt_pkg.sv
package dtt_pkg;
  localparam int NUM_TMR = 2;
  localparam int CTRL_EXTRA = 10;

  typedef enum logic [1:0] {
    SRC_SYS   = 2'd0,
    SRC_SLOW  = 2'd1,
    SRC_PSC   = 2'd2,
    SRC_CHAIN = 2'd3
  } tsrc_e;

  // bit positions of the non-divisor control fields, relative to 2*cnt_w
  function automatic int run_bit(int cnt_w, int idx);
    return 2 * cnt_w + idx;
  endfunction

  function automatic int src_lsb(int cnt_w, int idx);
    return 2 * cnt_w + 2 + 2 * idx;
  endfunction

  function automatic int clr_bit(int cnt_w, int idx);
    return 2 * cnt_w + 6 + idx;
  endfunction

  function automatic int mask_bit(int cnt_w, int idx);
    return 2 * cnt_w + 8 + idx;
  endfunction
endpackage

// File: rtl/dtt_prescaler.sv
module dtt_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [PSC_W-1:0] wdata_i,
  output logic [PSC_W-1:0] cnt_o,
  output logic [PSC_W-1:0] div_o,
  output logic             pulse_o
);
  localparam logic [PSC_W-1:0] MIN_DIV = PSC_W'(2);
  localparam logic [PSC_W-1:0] ONE     = PSC_W'(1);

  function automatic logic [PSC_W-1:0] clamp_div(logic [PSC_W-1:0] v);
    return (v < MIN_DIV) ? MIN_DIV : v;
  endfunction

  function automatic logic [PSC_W-1:0] mid_point(logic [PSC_W-1:0] d);
    return d >> 1;
  endfunction

  logic [PSC_W-1:0] cnt_q, div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= MIN_DIV;
      div_q <= MIN_DIV;
    end else if (we_i) begin
      cnt_q <= clamp_div(wdata_i);
      div_q <= clamp_div(wdata_i);
    end else if (cnt_q == ONE) begin
      cnt_q <= div_q;
    end else begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign pulse_o = (cnt_q == mid_point(div_q));
  assign cnt_o   = cnt_q;
  assign div_o   = div_q;
endmodule

// File: rtl/dtt_ctrl.sv
module dtt_ctrl
  import dtt_pkg::*;
#(
  parameter int CNT_W = 8,
  localparam int CTRL_W = 2 * CNT_W + CTRL_EXTRA
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we_i,
  input  logic [CTRL_W-1:0]               wdata_i,
  output logic [NUM_TMR-1:0][CNT_W-1:0]   div_eff_o,
  output logic [NUM_TMR-1:0]              run_eff_o,
  output logic [NUM_TMR-1:0][1:0]         src_eff_o,
  output logic [NUM_TMR-1:0]              clr_cmd_o,
  output logic [NUM_TMR-1:0]              mask_o
);
  for (genvar i = 0; i < NUM_TMR; i++) begin : g_fld
    localparam int DLSB = i * CNT_W;
    localparam int RB   = run_bit(CNT_W, i);
    localparam int SB   = src_lsb(CNT_W, i);
    localparam int CB   = clr_bit(CNT_W, i);
    localparam int MB   = mask_bit(CNT_W, i);

    logic [CNT_W-1:0] div_q;
    logic             run_q;
    logic [1:0]       src_q;
    logic             mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        div_q  <= '0;
        run_q  <= 1'b0;
        src_q  <= 2'd0;
        mask_q <= 1'b0;
      end else if (we_i) begin
        div_q  <= wdata_i[DLSB +: CNT_W];
        run_q  <= wdata_i[RB];
        src_q  <= wdata_i[SB +: 2];
        mask_q <= wdata_i[MB];
      end
    end

    // a write governs the update at the edge that takes it
    assign div_eff_o[i] = we_i ? wdata_i[DLSB +: CNT_W] : div_q;
    assign run_eff_o[i] = we_i ? wdata_i[RB] : run_q;
    assign src_eff_o[i] = we_i ? wdata_i[SB +: 2] : src_q;
    assign clr_cmd_o[i] = we_i & wdata_i[CB];
    assign mask_o[i]    = mask_q;
  end
endmodule

// File: rtl/dtt_counter.sv
module dtt_counter
  import dtt_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter bit CHAIN_OK = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] div_i,
  input  logic             run_i,
  input  logic [1:0]       src_i,
  input  logic             psc_pulse_i,
  input  logic             slow_tick_i,
  input  logic             chain_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tick_o,
  output logic             uf_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] step_down(logic [CNT_W-1:0] c);
    return c - ONE;  // 0 stands for 2**CNT_W and wraps to all ones
  endfunction

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             chain_tick;

  if (CHAIN_OK) begin : g_chain
    assign chain_tick = chain_i;
  end else begin : g_nochain
    assign chain_tick = 1'b0 & chain_i;
  end

  always_comb begin
    unique case (tsrc_e'(src_i))
      SRC_SYS:   tick_o = 1'b1;
      SRC_SLOW:  tick_o = slow_tick_i;
      SRC_PSC:   tick_o = psc_pulse_i;
      SRC_CHAIN: tick_o = chain_tick;
      default:   tick_o = 1'b0;
    endcase
  end

  assign uf_o = run_i & tick_o & (cnt_q == ONE);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)      cnt_d = div_i;
    else if (uf_o)   cnt_d = div_i;
    else if (tick_o) cnt_d = step_down(cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dtt_irq.sv
module dtt_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] uf_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] irq_o
);
  logic [N-1:0] pend_q;

  for (genvar i = 0; i < N; i++) begin : g_pend
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pend_q[i] <= 1'b0;
      else if (uf_i[i]) pend_q[i] <= 1'b1;   // a new underflow beats a clear
      else if (clr_i[i]) pend_q[i] <= 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = pend_q & mask_i;
endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
  import dtt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PSC_W = 16,
  localparam int CTRL_W = 2 * CNT_W + CTRL_EXTRA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              psc_we,
  input  logic [PSC_W-1:0]  psc_wdata,
  input  logic              slow_tick,
  output logic [CNT_W-1:0]  cnt0,
  output logic [CNT_W-1:0]  cnt1,
  output logic [PSC_W-1:0]  psc_cnt,
  output logic [1:0]        irq
);
  logic [PSC_W-1:0]              psc_div_w;
  logic                          psc_pulse_w;
  logic [NUM_TMR-1:0][CNT_W-1:0] div_eff;
  logic [NUM_TMR-1:0]            run_eff;
  logic [NUM_TMR-1:0][1:0]       src_eff;
  logic [NUM_TMR-1:0]            clr_cmd;
  logic [NUM_TMR-1:0]            mask_q;
  logic [NUM_TMR-1:0][CNT_W-1:0] cnt_vec;
  logic [NUM_TMR-1:0]            tick_vec;
  logic [NUM_TMR-1:0]            pend_vec;
  logic                          uf_head, uf_tail;
  logic [NUM_TMR-1:0]            uf_vec;

  dtt_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (psc_we),
    .wdata_i (psc_wdata),
    .cnt_o   (psc_cnt),
    .div_o   (psc_div_w),
    .pulse_o (psc_pulse_w)
  );

  dtt_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_i      (ctrl_we),
    .wdata_i   (ctrl_wdata),
    .div_eff_o (div_eff),
    .run_eff_o (run_eff),
    .src_eff_o (src_eff),
    .clr_cmd_o (clr_cmd),
    .mask_o    (mask_q)
  );

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    if (i == 0) begin : g_head
      dtt_counter #(.CNT_W(CNT_W), .CHAIN_OK(1'b0)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .div_i       (div_eff[i]),
        .run_i       (run_eff[i]),
        .src_i       (src_eff[i]),
        .psc_pulse_i (psc_pulse_w),
        .slow_tick_i (slow_tick),
        .chain_i     (1'b0),
        .cnt_o       (cnt_vec[i]),
        .tick_o      (tick_vec[i]),
        .uf_o        (uf_head)
      );
    end else begin : g_link
      dtt_counter #(.CNT_W(CNT_W), .CHAIN_OK(1'b1)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .div_i       (div_eff[i]),
        .run_i       (run_eff[i]),
        .src_i       (src_eff[i]),
        .psc_pulse_i (psc_pulse_w),
        .slow_tick_i (slow_tick),
        .chain_i     (uf_head),
        .cnt_o       (cnt_vec[i]),
        .tick_o      (tick_vec[i]),
        .uf_o        (uf_tail)
      );
    end
  end

  assign uf_vec = {uf_tail, uf_head};

  dtt_irq #(.N(NUM_TMR)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .uf_i   (uf_vec),
    .clr_i  (clr_cmd),
    .mask_i (mask_q),
    .pend_o (pend_vec),
    .irq_o  (irq)
  );

  assign cnt0 = cnt_vec[0];
  assign cnt1 = cnt_vec[1];
endmodule

// File: rtl/dtt_checker.sv
module dtt_checker #(
  parameter int CNT_W = 8,
  parameter int PSC_W = 16,
  localparam int CTRL_W = 2 * CNT_W + 10,
  localparam int RUN0   = 2 * CNT_W
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ctrl_we,
  input logic [CTRL_W-1:0]     ctrl_wdata,
  input logic                  psc_we,
  input logic [PSC_W-1:0]      psc_cnt,
  input logic [PSC_W-1:0]      psc_div_w,
  input logic [CNT_W-1:0]      cnt0,
  input logic [1:0]            uf_vec,
  input logic [1:0]            tick_vec,
  input logic [1:0]            pend_vec,
  input logic [1:0]            run_eff,
  input logic [1:0][1:0]       src_eff,
  input logic [1:0][CNT_W-1:0] div_eff,
  input logic [1:0]            clr_cmd
);
  p_psc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!psc_we && psc_cnt > PSC_W'(1)) |=> psc_cnt == $past(psc_cnt) - PSC_W'(1));

  p_psc_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!psc_we && psc_cnt == PSC_W'(1)) |=> psc_cnt == $past(psc_div_w));

  p_hold_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && !ctrl_wdata[RUN0]) |=> cnt0 == $past(ctrl_wdata[CNT_W-1:0]));

  p_uf_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    uf_vec[0] |=> cnt0 == $past(div_eff[0]));

  p_head_nochain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_eff[0] == 2'd3) |-> !tick_vec[0]);

  p_chain_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_eff[1] && src_eff[1] == 2'd3 && uf_vec[0]) |-> tick_vec[1]);

  p_pend_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    uf_vec[1] |=> pend_vec[1]);

  p_pend_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vec[0] && !clr_cmd[0]) |=> pend_vec[0]);
endmodule

bind dual_tick_timer dtt_checker #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctrl_we    (ctrl_we),
  .ctrl_wdata (ctrl_wdata),
  .psc_we     (psc_we),
  .psc_cnt    (psc_cnt),
  .psc_div_w  (psc_div_w),
  .cnt0       (cnt0),
  .uf_vec     (uf_vec),
  .tick_vec   (tick_vec),
  .pend_vec   (pend_vec),
  .run_eff    (run_eff),
  .src_eff    (src_eff),
  .div_eff    (div_eff),
  .clr_cmd    (clr_cmd)
);

// File: tb/sim_dual_tick_timer.sv
module sim_dual_tick_timer;
  localparam int CW = 8;
  localparam int PW = 16;
  localparam int WW = 2 * CW + 10;
  localparam int B  = 2 * CW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctrl_we = 1'b0;
  logic [WW-1:0] ctrl_wdata = '0;
  logic          psc_we = 1'b0;
  logic [PW-1:0] psc_wdata = '0;
  logic          slow_tick = 1'b0;
  logic [CW-1:0] cnt0, cnt1;
  logic [PW-1:0] psc_cnt;
  logic [1:0]    irq;

  always #2.5 clk = ~clk;

  dual_tick_timer #(.CNT_W(CW), .PSC_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .psc_we(psc_we), .psc_wdata(psc_wdata), .slow_tick(slow_tick),
    .cnt0(cnt0), .cnt1(cnt1), .psc_cnt(psc_cnt), .irq(irq)
  );

  int    checks = 0;
  int    errors = 0;
  string phase = "R1";
  bit    slow_on = 0;
  int    cyc = 0;
  bit    done = 0;

  // behavioural reference state
  int m_pdiv = 2, m_pcnt = 2;
  int m_div [2] = '{0, 0};
  int m_run [2] = '{0, 0};
  int m_src [2] = '{0, 0};
  int m_msk [2] = '{0, 0};
  int m_cnt [2] = '{0, 0};
  int m_pnd [2] = '{0, 0};

  always @(posedge clk) begin
    int pulse, w, d, r, s, tk, uf0, uf;
    if (!rst_n) begin
      m_pdiv = 2; m_pcnt = 2;
      for (int i = 0; i < 2; i++) begin
        m_div[i] = 0; m_run[i] = 0; m_src[i] = 0; m_msk[i] = 0; m_cnt[i] = 0; m_pnd[i] = 0;
      end
    end else begin
      pulse = (m_pcnt == m_pdiv / 2);
      w = int'(ctrl_wdata);
      uf0 = 0;
      for (int i = 0; i < 2; i++) begin
        d = ctrl_we ? ((w >> (CW * i)) & 255) : m_div[i];
        r = ctrl_we ? ((w >> (B + i)) & 1) : m_run[i];
        s = ctrl_we ? ((w >> (B + 2 + 2 * i)) & 3) : m_src[i];
        case (s)
          0: tk = 1;
          1: tk = slow_tick;
          2: tk = pulse;
          default: tk = (i == 1) ? uf0 : 0;
        endcase
        uf = r && tk && (m_cnt[i] == 1);
        if (i == 0) uf0 = uf;
        if (!r) m_cnt[i] = d;
        else if (tk) m_cnt[i] = (m_cnt[i] == 1) ? d : ((m_cnt[i] + 255) % 256);
        if (uf) m_pnd[i] = 1;
        else if (ctrl_we && ((w >> (B + 6 + i)) & 1)) m_pnd[i] = 0;
        if (ctrl_we) begin
          m_div[i] = d; m_run[i] = r; m_src[i] = s; m_msk[i] = (w >> (B + 8 + i)) & 1;
        end
      end
      if (psc_we) begin
        m_pdiv = (psc_wdata < 2) ? 2 : int'(psc_wdata);
        m_pcnt = m_pdiv;
      end else if (m_pcnt == 1) m_pcnt = m_pdiv;
      else m_pcnt = m_pcnt - 1;
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", phase, what, act, exp);
    end
  endtask

  // compare every cycle on the falling edge, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("cnt0", int'(cnt0), m_cnt[0]);
      chk("cnt1", int'(cnt1), m_cnt[1]);
      chk("psc_cnt", int'(psc_cnt), m_pcnt);
      chk("irq", int'(irq), (m_pnd[1] & m_msk[1]) * 2 + (m_pnd[0] & m_msk[0]));
    end
  end

  task automatic drive_idle();
    @(negedge clk);
    ctrl_we = 1'b0;
    psc_we = 1'b0;
    slow_tick = slow_on && (cyc % 3 == 0);
    cyc++;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) drive_idle();
  endtask

  task automatic wr_ctrl(logic [WW-1:0] word);
    drive_idle();
    ctrl_we = 1'b1;
    ctrl_wdata = word;
  endtask

  task automatic wr_psc(int v);
    drive_idle();
    psc_we = 1'b1;
    psc_wdata = PW'(v);
  endtask

  function automatic logic [WW-1:0] mk(int d0, int d1, int r0, int r1, int s0, int s1,
                                       int c0, int c1, int k0, int k1);
    logic [WW-1:0] v;
    v = '0;
    v[CW-1:0] = CW'(d0);
    v[2*CW-1:CW] = CW'(d1);
    v[B] = r0[0];
    v[B+1] = r1[0];
    v[B+3:B+2] = s0[1:0];
    v[B+5:B+4] = s1[1:0];
    v[B+6] = c0[0];
    v[B+7] = c1[0];
    v[B+8] = k0[0];
    v[B+9] = k1[0];
    return v;
  endfunction

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL %s watchdog actual 0 expected 1", phase);
    finish_run();
  end

  initial begin
    // R1: reset values
    repeat (3) @(negedge clk);
    chk("R1 cnt0", int'(cnt0), 0);
    chk("R1 cnt1", int'(cnt1), 0);
    chk("R1 psc_cnt", int'(psc_cnt), 2);
    chk("R1 irq", int'(irq), 0);
    rst_n = 1'b1;
    idle(4);

    phase = "R2";
    wr_psc(5);  idle(20);
    wr_psc(0);  idle(8);
    wr_psc(1);  idle(5);
    wr_psc(9);  idle(20);

    phase = "R4";
    wr_ctrl(mk(9, 3, 0, 0, 0, 0, 0, 0, 0, 0)); idle(4);
    wr_ctrl(mk(200, 17, 0, 0, 1, 2, 0, 0, 0, 0)); idle(3);

    phase = "R5";
    wr_ctrl(mk(4, 5, 1, 1, 0, 0, 0, 0, 1, 1)); idle(30);

    phase = "R8";
    for (int k = 0; k < 14; k++) wr_ctrl(mk(4, 5, 1, 1, 0, 0, 1, 1, 1, 1));
    idle(6);

    phase = "R9";
    wr_ctrl(mk(4, 5, 1, 1, 0, 0, 0, 0, 1, 1)); idle(12);

    phase = "R10";
    wr_ctrl(mk(4, 5, 1, 1, 0, 0, 0, 0, 0, 1)); idle(10);
    wr_ctrl(mk(4, 5, 1, 1, 0, 0, 0, 0, 1, 0)); idle(10);

    phase = "R6";
    slow_on = 1;
    wr_ctrl(mk(3, 2, 1, 1, 1, 1, 1, 1, 1, 1)); idle(40);
    slow_on = 0;
    wr_ctrl(mk(5, 5, 1, 1, 3, 0, 1, 1, 1, 1)); idle(20);

    phase = "R3";
    wr_psc(6);
    wr_ctrl(mk(3, 4, 1, 1, 2, 2, 1, 1, 1, 1)); idle(120);

    phase = "R7";
    wr_ctrl(mk(3, 2, 1, 1, 0, 3, 1, 1, 1, 1)); idle(40);
    wr_ctrl(mk(3, 2, 0, 1, 0, 3, 1, 1, 1, 1)); idle(10);

    phase = "R11";
    wr_ctrl(mk(0, 0, 1, 1, 0, 0, 1, 1, 1, 1)); idle(600);
    wr_ctrl(mk(0, 0, 1, 1, 0, 3, 1, 1, 1, 1)); idle(700);

    finish_run();
  end
endmodule